// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is a small up-counter for a processor's peripheral space. It advances on an instruction-cycle tick that first passes through a prescaler, which divides by 1, 4 or 16. The counter climbs from zero. Once it equals a programmable period value, the next advance returns it to zero rather than letting it run on. That return is the match event. It is driven out for one clock as a time base for a downstream PWM stage.

Match events also feed a 4-bit postscaler, which divides them by a count from 1 to 16. The postscaler's terminal count sets a sticky interrupt flag. The host can load the counter, the period value and a control word. The control word holds the run bit, the prescale code and the postscale code. The host clears the flag with a separate strobe.

Top module: `period_timer`

## Requirements
- R1: After reset, count_o is 0, period_o is all ones, flag_o is 0, match_o is 0, and the control word is zero (stopped, prescale code 0, postscale code 0).
- R2: While running, the counter advances by one on every prescaler output. When an advance occurs with count_o equal to period_o, the counter becomes 0 instead.
- R3: A match requires exact equality. A count loaded above the period runs up to all ones, wraps to 0 with no match, and then counts on to the period.
- R4: The 2-bit prescale code sets how many ticks give one advance: code 0 gives 1, code 1 gives 4, and codes 2 and 3 both give 16.
- R5: With postscale code n (0 to 15), flag_o is set on every (n+1)-th match event.
- R6: flag_o stays set until a flag_clr_i strobe. If a setting event and a clear strobe occur in the same cycle, the flag ends up set.
- R7: When the run bit is 0, ticks are ignored: count_o and the prescaler hold their values.
- R8: A counter write loads wdata_i into the counter. A counter write or a control write clears the prescaler count and the postscaler count, and no advance happens in a cycle that carries either write.
- R9: A period write is visible on period_o in the next cycle and is used by every later compare.
- R10: match_o is high only during the one clock whose advance returns the counter to 0. In that clock, count_o equals period_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Instruction-cycle tick enable |
| wr_cnt_i | input | 1 | Load the counter from wdata_i |
| wr_per_i | input | 1 | Load the period from wdata_i |
| wr_ctl_i | input | 1 | Load the control word from the ctl_*_i inputs |
| wdata_i | input | CNT_W | Write data for the counter or the period |
| ctl_on_i | input | 1 | Run bit to write |
| ctl_pre_i | input | 2 | Prescale code to write |
| ctl_post_i | input | POST_W | Postscale code to write |
| flag_clr_i | input | 1 | Clear strobe for the interrupt flag |
| count_o | output | CNT_W | Current count |
| period_o | output | CNT_W | Current period value |
| ctl_on_o | output | 1 | Current run bit |
| ctl_pre_o | output | 2 | Current prescale code |
| ctl_post_o | output | POST_W | Current postscale code |
| flag_o | output | 1 | Sticky interrupt flag |
| match_o | output | 1 | One-clock match pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 4-bit postscaler and a 4-bit prescale counter. With these values the full postscale range, 1:1 through 1:16, can be reached within a few dozen ticks by using a period of 0. The 1:16 prescaler, with both of its codes, can be reached within a few hundred ticks. The wrap past all ones with no match can be reached by loading a count near 255. Together these cover the exact-equality rule, the top of the postscale range, and both ways of clearing the prescaler and postscaler counts.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   typedef enum logic [1:0] {
      PRE_DIV1   = 2'b00,
      PRE_DIV4   = 2'b01,
      PRE_DIV16  = 2'b10,
      PRE_DIV16B = 2'b11
   } pre_code_e;

   localparam int PRE_LOG_MAX = 4;

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
   import ptmr_pkg::*;
#(
   parameter int PRE_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       en_i,
   input  logic       clr_i,
   input  logic [1:0] code_i,
   output logic       inc_o
);

   generate
      if (PRE_W < PRE_LOG_MAX) begin : g_bad_width
         $error("ptmr_prescale: PRE_W too small for 1:16");
      end
   endgenerate

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] last;

   always_comb begin
      case (pre_code_e'(code_i))
         PRE_DIV1: last = '0;
         PRE_DIV4: last = PRE_W'(3);
         default:  last = PRE_W'(15);
      endcase
   end

   assign inc_o = tick_i & en_i & ~clr_i & (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr_i)         cnt_q <= '0;
      else if (tick_i && en_i) cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
   end

   AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= last); // R4
   AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !clr_i) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/ptmr_period.sv
module ptmr_period #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             wr_cnt_i,
   input  logic             wr_per_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] per_o,
   output logic             match_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic             hit;

   assign hit     = (cnt_q == per_q);
   assign match_o = inc_i & hit;
   assign cnt_o   = cnt_q;
   assign per_o   = per_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (wr_cnt_i) cnt_q <= wdata_i;
      else if (inc_i)    cnt_q <= hit ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        per_q <= '1;
      else if (wr_per_i) per_q <= wdata_i;
   end

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && !wr_cnt_i) |=> (cnt_q == '0)); // R2
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !match_o && !wr_cnt_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !wr_cnt_i) |=> $stable(cnt_q)); // R7
   AST_PER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_per_i |=> (per_q == $past(wdata_i))); // R9

endmodule

// File: rtl/ptmr_postscale.sv
module ptmr_postscale #(
   parameter int POST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              match_i,
   input  logic              clr_i,
   input  logic [POST_W-1:0] sel_i,
   input  logic              flag_clr_i,
   output logic              flag_o
);

   logic [POST_W-1:0] cnt_q;
   logic              flag_q;
   logic              done;

   assign done   = match_i & (cnt_q == sel_i);
   assign flag_o = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (match_i) cnt_q <= (cnt_q == sel_i) ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (done)       flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
   end

   AST_POST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= sel_i); // R5
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr_i) |=> flag_q); // R6
   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(match_i)); // R5

endmodule

// File: rtl/period_timer.sv
module period_timer
   import ptmr_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int POST_W = 4,
   parameter int PRE_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_cnt_i,
   input  logic              wr_per_i,
   input  logic              wr_ctl_i,
   input  logic [CNT_W-1:0]  wdata_i,
   input  logic              ctl_on_i,
   input  logic [1:0]        ctl_pre_i,
   input  logic [POST_W-1:0] ctl_post_i,
   input  logic              flag_clr_i,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  period_o,
   output logic              ctl_on_o,
   output logic [1:0]        ctl_pre_o,
   output logic [POST_W-1:0] ctl_post_o,
   output logic              flag_o,
   output logic              match_o
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("period_timer: CNT_W must be at least 2");
      end
      if (POST_W < 1 || POST_W > 8) begin : g_bad_post
         $error("period_timer: POST_W out of range");
      end
   endgenerate

   logic              on_q;
   logic [1:0]        pre_q;
   logic [POST_W-1:0] post_q;
   logic              sub_clr;
   logic              inc;
   logic              match;

   assign sub_clr = wr_cnt_i | wr_ctl_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q   <= 1'b0;
         pre_q  <= PRE_DIV1;
         post_q <= '0;
      end else if (wr_ctl_i) begin
         on_q   <= ctl_on_i;
         pre_q  <= ctl_pre_i;
         post_q <= ctl_post_i;
      end
   end

   ptmr_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .en_i   (on_q),
      .clr_i  (sub_clr),
      .code_i (pre_q),
      .inc_o  (inc)
   );

   ptmr_period #(.CNT_W(CNT_W)) u_per (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (inc),
      .wr_cnt_i (wr_cnt_i),
      .wr_per_i (wr_per_i),
      .wdata_i  (wdata_i),
      .cnt_o    (count_o),
      .per_o    (period_o),
      .match_o  (match)
   );

   ptmr_postscale #(.POST_W(POST_W)) u_post (
      .clk        (clk),
      .rst_n      (rst_n),
      .match_i    (match),
      .clr_i      (sub_clr),
      .sel_i      (post_q),
      .flag_clr_i (flag_clr_i),
      .flag_o     (flag_o)
   );

   assign match_o    = match;
   assign ctl_on_o   = on_q;
   assign ctl_pre_o  = pre_q;
   assign ctl_post_o = post_q;

   AST_MATCH_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> (count_o == period_o)); // R10
   AST_NO_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl_i && !wr_cnt_i) |=> $stable(count_o)); // R8
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!on_q && !wr_cnt_i) |=> $stable(count_o)); // R7

endmodule

// File: tb/period_timer_bench.sv
module period_timer_bench;

   localparam int CNT_W  = 8;
   localparam int POST_W = 4;
   localparam int NVEC   = 11;

   // columns: prescale code, postscale code, period, ticks, expected count, expected flag
   localparam int VEC [NVEC][6] = '{
      '{0, 0,   9, 25,   5, 1},
      '{0, 3,   4, 19,   4, 0},
      '{0, 3,   4, 20,   0, 1},
      '{1, 0,   2, 11,   2, 0},
      '{1, 0,   2, 12,   0, 1},
      '{2, 0,   0, 47,   0, 1},
      '{3, 1,   1, 63,   1, 0},
      '{3, 1,   1, 64,   0, 1},
      '{0, 15,  0, 15,   0, 0},
      '{0, 15,  0, 16,   0, 1},
      '{0, 0, 255, 200, 200, 0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_i = 1'b0;
   logic              wr_cnt_i = 1'b0;
   logic              wr_per_i = 1'b0;
   logic              wr_ctl_i = 1'b0;
   logic [CNT_W-1:0]  wdata_i = '0;
   logic              ctl_on_i = 1'b0;
   logic [1:0]        ctl_pre_i = '0;
   logic [POST_W-1:0] ctl_post_i = '0;
   logic              flag_clr_i = 1'b0;
   logic [CNT_W-1:0]  count_o;
   logic [CNT_W-1:0]  period_o;
   logic              ctl_on_o;
   logic [1:0]        ctl_pre_o;
   logic [POST_W-1:0] ctl_post_o;
   logic              flag_o;
   logic              match_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   period_timer u_period_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .wr_cnt_i   (wr_cnt_i),
      .wr_per_i   (wr_per_i),
      .wr_ctl_i   (wr_ctl_i),
      .wdata_i    (wdata_i),
      .ctl_on_i   (ctl_on_i),
      .ctl_pre_i  (ctl_pre_i),
      .ctl_post_i (ctl_post_i),
      .flag_clr_i (flag_clr_i),
      .count_o    (count_o),
      .period_o   (period_o),
      .ctl_on_o   (ctl_on_o),
      .ctl_pre_o  (ctl_pre_o),
      .ctl_post_o (ctl_post_o),
      .flag_o     (flag_o),
      .match_o    (match_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic put_ctl(input bit on, input int pre, input int post);
      @(negedge clk);
      wr_ctl_i = 1'b1; ctl_on_i = on; ctl_pre_i = 2'(pre); ctl_post_i = POST_W'(post);
      @(negedge clk);
      wr_ctl_i = 1'b0;
   endtask

   task automatic put_cnt(input int v);
      @(negedge clk);
      wr_cnt_i = 1'b1; wdata_i = CNT_W'(v);
      @(negedge clk);
      wr_cnt_i = 1'b0;
   endtask

   task automatic put_per(input int v);
      @(negedge clk);
      wr_per_i = 1'b1; wdata_i = CNT_W'(v);
      @(negedge clk);
      wr_per_i = 1'b0;
   endtask

   task automatic clr_flag();
      @(negedge clk);
      flag_clr_i = 1'b1;
      @(negedge clk);
      flag_clr_i = 1'b0;
   endtask

   task automatic run(input int n);
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
      #1;
   endtask

   task automatic setup(input int pre, input int post, input int per, input int cnt);
      put_ctl(1'b1, pre, post);
      put_per(per);
      put_cnt(cnt);
      clr_flag();
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int prev;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 count", int'(count_o), 0);
      chk("R1 period", int'(period_o), 255);
      chk("R1 flag", int'(flag_o), 0);
      chk("R1 match", int'(match_o), 0);
      chk("R1 ctl", int'({ctl_on_o, ctl_pre_o, ctl_post_o}), 0);
      rst_n = 1'b1;

      // R2 R4 R5 R9 vector table
      for (int i = 0; i < NVEC; i++) begin
         setup(VEC[i][0], VEC[i][1], VEC[i][2], 0);
         chk($sformatf("R9 period v%0d", i), int'(period_o), VEC[i][2]);
         run(VEC[i][3]);
         chk($sformatf("R2 R4 count v%0d", i), int'(count_o), VEC[i][4]);
         chk($sformatf("R5 flag v%0d", i), int'(flag_o), VEC[i][5]);
      end

      // R10 match pulse width and alignment
      setup(0, 0, 2, 0);
      @(negedge clk);
      tick_i = 1'b1;
      #1;
      for (int k = 0; k < 6; k++) begin
         chk("R10 count", int'(count_o), k % 3);
         chk("R10 match", int'(match_o), (k % 3 == 2) ? 1 : 0);
         @(negedge clk);
         #1;
      end
      tick_i = 1'b0;

      // R3 count above period wraps without match
      setup(0, 0, 5, 250);
      run(6);
      chk("R3 wrap count", int'(count_o), 0);
      chk("R3 no flag", int'(flag_o), 0);
      run(5);
      chk("R3 reach period", int'(count_o), 5);
      chk("R3 still no flag", int'(flag_o), 0);
      run(1);
      chk("R3 match", int'(count_o), 0);
      chk("R3 flag", int'(flag_o), 1);

      // R8 counter write clears prescaler
      setup(1, 0, 255, 0);
      run(3);
      put_cnt(7);
      run(3);
      chk("R8 cnt write", int'(count_o), 7);
      run(1);
      chk("R8 after prescale", int'(count_o), 8);
      // R8 control write clears prescaler
      run(3);
      put_ctl(1'b1, 1, 0);
      run(3);
      chk("R8 ctl write pre", int'(count_o), 8);
      run(1);
      chk("R8 ctl write pre step", int'(count_o), 9);

      // R8 control write clears postscaler
      setup(0, 1, 0, 0);
      run(1);
      chk("R8 post first", int'(flag_o), 0);
      put_ctl(1'b1, 0, 1);
      run(1);
      chk("R8 post cleared", int'(flag_o), 0);
      run(1);
      chk("R8 post second", int'(flag_o), 1);

      // R7 stopped timer ignores ticks
      setup(0, 0, 255, 40);
      put_ctl(1'b0, 0, 0);
      prev = int'(count_o);
      run(10);
      chk("R7 hold", int'(count_o), prev);
      put_ctl(1'b1, 0, 0);
      run(2);
      chk("R7 resume", int'(count_o), prev + 2);

      // R6 set wins over clear, then sticky, then clear
      setup(0, 0, 0, 0);
      @(negedge clk);
      tick_i = 1'b1; flag_clr_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0; flag_clr_i = 1'b0;
      #1;
      chk("R6 set wins", int'(flag_o), 1);
      put_per(255);
      run(5);
      chk("R6 sticky", int'(flag_o), 1);
      clr_flag();
      #1;
      chk("R6 cleared", int'(flag_o), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule